// File: doc/BRIEF.md
# Square-Wave Beeper with Pulse-Density Volume

This peripheral plays a single square-wave tone whose pitch, loudness and length are set by a host over a Wishbone slave register port. A phase accumulator advances by a host-programmed increment once per audio sample, and its most significant bit is the tone. The host converts notes to increments, so the hardware only ever sees the per-sample phase step.

Loudness is set per output pin. Four pins feed an external resistor DAC whose weights are deliberately nonlinear, with pin 3 the heaviest and pin 0 the lightest. Each pin has its own 4-bit gain and its own free-running 4-bit pulse-density counter. While the tone is high, the pin pulses for a fraction gain/16 of the fast clock. When the tone is low, every pin is held low.

A millisecond duration counter limits the tone. Writing a nonzero length starts the tone from phase zero. The tone stops when the count runs out, or at once when the host writes zero.

Top module: `tone_beeper`

## Requirements
- R1: After synchronous reset, all pins are low, the ACK is low, and the increment, gain and duration registers all read back as zero.
- R2: A bus access with CYC and STB high is acknowledged by an ACK pulse one clock after STB is first seen. The pulse lasts exactly one cycle, and a write takes effect on that access.
- R3: Register map, selected by the 2-bit word address. Address 0 holds the 24-bit phase increment in data bits 23:0, and the upper bits read as zero. Address 1 holds the gains: pin 3 in bits 15:12, pin 2 in 11:8, pin 1 in 7:4, pin 0 in 3:0. Address 2 holds the 8-bit duration in bits 7:0. Address 3 reads zero.
- R4: While a tone plays, the phase accumulator adds the increment once every CLK_HZ/SAMPLE_HZ clocks, and the tone is the accumulator's top bit. An increment of 2^22 therefore gives a period of 4 samples, and 2^21 gives 8 samples. An increment of zero written before a start keeps the tone silent.
- R5: While the tone is high, a pin with gain N is high in exactly N out of any 16 consecutive clocks. While the tone is low, all four pins are low.
- R6: Writing a nonzero duration D clears the phase, restarts the sample and millisecond dividers, and plays for exactly D×(CLK_HZ/TICK_HZ) clocks. Reading address 2 returns the milliseconds that remain. Once the count is zero, all pins stay low.
- R7: Writing zero to the duration register stops the tone on the next clock, and the register reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 2 | Register word address |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid with the ACK |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| dac_o | output | PINS | Pulse-density pins to the weighted resistor DAC, bit 3 heaviest |

## Verification
Assertions check four things on every cycle:
- The ACK is a lone pulse caused by a strobe.
- The phase only moves on a sample strobe or a start.
- No pin rises unless the tone bit was high a cycle earlier, and the pins go quiet once the duration is exhausted.
- The duration count only steps down by one, except on a host write.

Other behaviours need a whole window of cycles, so only the bench's directed scenarios can show them. These are the exact pulse counts per gain, the tone period for each increment, the precise tone length in milliseconds, the nibble order of the gains, and the phase restart.

// File: rtl/tone_beeper.sv
module tone_beeper #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SAMPLE_HZ = 100_000,
  parameter int TICK_HZ   = 1000,
  parameter int PHASE_W   = 24,
  parameter int PINS      = 4,
  parameter int GAIN_W    = 4,
  parameter int DUR_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [1:0]        wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic [PINS-1:0]   dac_o
);
  localparam int SDIV = CLK_HZ / SAMPLE_HZ;
  localparam int MDIV = CLK_HZ / TICK_HZ;
  localparam int SW   = (SDIV > 1) ? $clog2(SDIV) : 1;
  localparam int MW   = (MDIV > 1) ? $clog2(MDIV) : 1;
  localparam int GW   = PINS * GAIN_W;

  logic [PHASE_W-1:0] inc_q, phase_q;
  logic [GW-1:0]      gain_q;
  logic [DUR_W-1:0]   dur_q;
  logic [SW-1:0]      sdiv_q;
  logic [MW-1:0]      mdiv_q;
  logic [PINS-1:0]    hit;

  wire access   = wb_cyc_i && wb_stb_i && !wb_ack_o;
  wire wr       = access && wb_we_i;
  wire wr_inc   = wr && wb_adr_i == 2'd0;
  wire wr_gain  = wr && wb_adr_i == 2'd1;
  wire wr_dur   = wr && wb_adr_i == 2'd2;
  wire start    = wr_dur && wb_dat_i[DUR_W-1:0] != '0;
  wire s_stb    = sdiv_q == SW'(SDIV - 1);
  wire m_tick   = mdiv_q == MW'(MDIV - 1);
  wire active   = dur_q != '0;
  wire tone     = active && phase_q[PHASE_W-1];
  wire unused_data = ^wb_dat_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q  <= '0;
      gain_q <= '0;
    end else begin
      if (wr_inc)  inc_q  <= wb_dat_i[PHASE_W-1:0];
      if (wr_gain) gain_q <= wb_dat_i[GW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start || s_stb) sdiv_q <= '0;
    else                       sdiv_q <= sdiv_q + SW'(1);
    if (rst || start || m_tick) mdiv_q <= '0;
    else                        mdiv_q <= mdiv_q + MW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || start)          phase_q <= '0;
    else if (active && s_stb)  phase_q <= phase_q + inc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                  dur_q <= '0;
    else if (wr_dur)          dur_q <= wb_dat_i[DUR_W-1:0];
    else if (active && m_tick) dur_q <= dur_q - DUR_W'(1);
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [GAIN_W-1:0] cnt;
    always_ff @(posedge clk) cnt <= rst ? '0 : cnt + GAIN_W'(1);
    assign hit[g] = cnt < gain_q[g*GAIN_W +: GAIN_W];
  end

  always_ff @(posedge clk) dac_o <= (rst || !tone) ? '0 : hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= access;
      if (access) begin
        case (wb_adr_i)
          2'd0:    wb_dat_o <= DATA_W'(inc_q);
          2'd1:    wb_dat_o <= DATA_W'(gain_q);
          2'd2:    wb_dat_o <= DATA_W'(dur_q);
          default: wb_dat_o <= '0;
        endcase
      end
    end
  end

  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);
  p_ack_cause_r2: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!s_stb && !start) |=> $stable(phase_q));
  p_pins_need_tone_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_o != '0) |-> $past(tone));
  p_dur_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_dur && active) |=> (dur_q == $past(dur_q) || dur_q == $past(dur_q) - DUR_W'(1)));
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> dac_o == '0);
  p_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_dur && wb_dat_i[DUR_W-1:0] == '0) |=> !active);
endmodule

// File: tb/tone_beeper_tb.sv
module tone_beeper_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [1:0] adr = 0;
  logic [31:0] wdat = 0, rdat;
  logic ack;
  logic [3:0] dac;
  logic [31:0] rd;
  int vectors = 0, errs = 0;
  int pc[4];
  int lowall;
  bit done = 0;

  always #2 clk = ~clk;

  tone_beeper #(.CLK_HZ(800), .SAMPLE_HZ(100), .TICK_HZ(4)) u_dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .dac_o(dac));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    chk("R2", "ack idle before edge", {31'b0, ack}, 0);
    @(negedge clk);
    chk("R2", "ack one cycle after stb", {31'b0, ack}, 1);
    q = rdat;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    chk("R2", "ack single pulse", {31'b0, ack}, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic count_pins(input int n);
    for (int i = 0; i < 4; i++) pc[i] = 0;
    lowall = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (dac[i]) pc[i]++;
      if (dac == 4'b0) lowall++;
    end
  endtask

  task automatic count_gaps(input int warm, input int n, output int ev);
    int run;
    run = 0; ev = 0;
    for (int k = 0; k < warm + n; k++) begin
      @(negedge clk);
      if (dac[3]) run = 0; else run++;
      if (run == 12 && k >= warm) ev++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "pins after reset", {28'b0, dac}, 0);
    chk("R1", "ack after reset", {31'b0, ack}, 0);
    bus(0, 2'd0, 0, rd); chk("R1", "increment reset", rd, 0);
    bus(0, 2'd1, 0, rd); chk("R1", "gain reset", rd, 0);
    bus(0, 2'd2, 0, rd); chk("R1", "duration reset", rd, 0);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    bus(0, 2'd0, 0, rd); chk("R3", "increment 24-bit readback", rd, 32'h00FF_FFFF);
    wr(2'd1, 32'hDEAD_BEEF);
    bus(0, 2'd1, 0, rd); chk("R3", "gain 16-bit readback", rd, 32'h0000_BEEF);
    wr(2'd3, 32'h1234_5678);
    bus(0, 2'd3, 0, rd); chk("R3", "address 3 reads zero", rd, 0);
    chk("R6", "no tone without duration", {28'b0, dac}, 0);
  endtask

  task automatic t_density();
    wr(2'd0, 32'h40_0000);
    wr(2'd1, 32'hF840);
    wr(2'd2, 20);
    repeat (64) @(negedge clk);
    count_pins(320);
    chk("R5", "pin3 gain 15 count", pc[3], 150);
    chk("R5", "pin2 gain 8 count", pc[2], 80);
    chk("R5", "pin1 gain 4 count", pc[1], 40);
    chk("R5", "pin0 gain 0 count", pc[0], 0);
    wr(2'd1, 32'h0137);
    repeat (64) @(negedge clk);
    count_pins(320);
    chk("R3", "pin3 top nibble gain 0", pc[3], 0);
    chk("R3", "pin2 gain 1 count", pc[2], 10);
    chk("R3", "pin1 gain 3 count", pc[1], 30);
    chk("R3", "pin0 gain 7 count", pc[0], 70);
    wr(2'd1, 32'hFFFF);
    repeat (64) @(negedge clk);
    count_pins(320);
    chk("R5", "all pins low while tone low", lowall, 170);
  endtask

  task automatic t_freq();
    int ev;
    wr(2'd1, 32'hF000);
    wr(2'd0, 32'h40_0000);
    wr(2'd2, 30);
    count_gaps(128, 512, ev);
    chk("R4", "low phases, increment 2^22", ev, 16);
    wr(2'd0, 32'h20_0000);
    count_gaps(128, 512, ev);
    chk("R4", "low phases, increment 2^21", ev, 8);
    wr(2'd0, 0);
    wr(2'd1, 32'hFFFF);
    wr(2'd2, 30);
    repeat (16) @(negedge clk);
    count_pins(256);
    chk("R4", "zero increment silent", lowall, 256);
  endtask

  task automatic t_duration();
    int any;
    wr(2'd0, 32'h40_0000);
    wr(2'd1, 32'hFFFF);
    wr(2'd2, 3);
    repeat (300) @(negedge clk);
    bus(0, 2'd2, 0, rd); chk("R6", "remaining ms mid tone", rd, 2);
    repeat (236) @(negedge clk);
    count_pins(32);
    any = pc[0] + pc[1] + pc[2] + pc[3];
    chk("R6", "tone still playing before end", {31'b0, any > 0}, 1);
    repeat (38) @(negedge clk);
    count_pins(64);
    chk("R6", "silent after duration", lowall, 64);
    bus(0, 2'd2, 0, rd); chk("R6", "duration reads zero at end", rd, 0);
    wr(2'd2, 40);
    while (dac == 4'b0) @(negedge clk);
    wr(2'd2, 40);
    count_pins(12);
    chk("R6", "restart clears phase", lowall, 12);
  endtask

  task automatic t_stop();
    repeat (100) @(negedge clk);
    wr(2'd2, 0);
    count_pins(64);
    chk("R7", "silent after stop write", lowall, 64);
    bus(0, 2'd2, 0, rd); chk("R7", "duration zero after stop", rd, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_density();
    t_freq();
    t_duration();
    t_stop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule